// File: doc/BRIEF.md
# HDLC Receive FIFO Controller

This block is the receive half of one HDLC channel. A serial-side deframer hands it one byte per cycle. With the last byte of a frame it also gives an end-of-frame flag and the frame checks (CRC valid, whole-octet length, abort). The block keeps the bytes in a 32-byte receive buffer. It raises a receive-ready interrupt when the buffer holds 32 bytes or when a frame end is waiting.

A host empties the buffer with 32-bit reads and follows the buffer state through a status word. The status word carries:
- the pending byte count;
- an end-of-message flag;
- a frame-quality field;
- a sticky overflow flag.

A receiver-reset command flushes the buffer and clears the overflow. In transparent mode the frame-end and check inputs are ignored, and the buffer is a plain byte stream that signals only when it is full.

The reset is asynchronous and active-low, and its release is expected to be already synchronised to `clk`.

Top module: `hdlc_rx_fifo_ctrl`

## Requirements
- R1: After reset, `status_word`, `host_rdata` and `rpr_irq` are all zero.
- R2: Bytes are read out in arrival order. A host read returns up to four bytes with the oldest in bits 7:0, and removes them from the buffer.
- R3: `status_word[13:8]` gives the pending byte count, with 32 encoded as 0. A buffer holding 32 bytes drives `rpr_irq` and `status_word[5]` high.
- R4: In frame mode, a byte taken with `rx_eof` high sets `status_word[0]` and raises the interrupt. The count field then shows only the bytes up to and including that frame end, even when later bytes arrive.
- R5: `status_word[3:1]` holds {abort, aligned, crc_ok}, latched with the frame-end byte. The value 3 means a good frame and any other value means an invalid frame. The field reads 0 while no frame end is pending.
- R6: A host read never crosses a pending frame end: it takes min(4, bytes left in the frame) and zero-fills the unused upper bytes. Once the last byte of the frame has been read, `status_word[0]` clears and the count shows the bytes that follow.
- R7: A read of an empty buffer returns zero and leaves the count unchanged.
- R8: A byte that arrives while 32 bytes are held is dropped and sets `status_word[4]`, which also raises the interrupt. From then on every incoming byte is dropped until a receiver reset, and the stored bytes stay intact.
- R9: In frame mode, a frame end that arrives while an earlier frame end is still pending is dropped and sets `status_word[4]`.
- R10: While `rx_reset_cmd` is high the buffer is emptied, pending frame end and overflow are cleared, and incoming bytes are ignored. After release the buffer works normally.
- R11: With `transparent_mode` high, `rx_eof` and the check inputs have no effect. `status_word[0]` and `status_word[3:1]` stay 0, and the interrupt is raised only by a full buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| transparent_mode | input | 1 | 1 = unframed byte stream, 0 = frame mode |
| rx_valid | input | 1 | A byte is offered this cycle |
| rx_byte | input | 8 | Received byte |
| rx_eof | input | 1 | This byte ends a frame |
| rx_crc_ok | input | 1 | Frame CRC correct (meaningful with rx_eof) |
| rx_aligned | input | 1 | Frame was a whole number of octets (meaningful with rx_eof) |
| rx_abort | input | 1 | Frame was aborted (meaningful with rx_eof) |
| rx_reset_cmd | input | 1 | Receiver reset command, level sensitive |
| host_rd | input | 1 | Host 32-bit read strobe |
| host_rdata | output | 32 | Read word, valid the cycle after host_rd |
| status_word | output | 32 | Count, end-of-message, quality, overflow, ready |
| rpr_irq | output | 1 | Receive-ready interrupt (mirror of status bit 5) |

## Verification
Every byte, frame end and reset command offered in a cycle shows in `status_word` and `rpr_irq` right after the next rising edge, with no further pipeline stage. The word for a `host_rd` appears in `host_rdata` after that same edge, and the drop in the count appears at the same time. The bench changes inputs only on falling edges, holds each strobe for exactly one cycle, and reads the outputs on the falling edge that follows. Every comparison therefore lands half a cycle after the edge that made the result.

// File: rtl/hrx_pkg.sv
package hrx_pkg;

  // Bytes delivered by one host read (32-bit host bus).
  localparam int HOST_BYTES = 4;

  // Status word bit positions decoded by host software.
  localparam int ST_EOM    = 0;
  localparam int ST_QUAL   = 1;
  localparam int ST_OVF    = 4;
  localparam int ST_READY  = 5;
  localparam int ST_CNT    = 8;
  localparam int CNT_FLD_W = 6;

  // Frame checks latched with the frame-end byte; MSB first in status.
  typedef struct packed {
    logic abort;
    logic aligned;
    logic crc_ok;
  } hrx_qual_t;

endpackage

// File: rtl/hrx_byte_store.sv
module hrx_byte_store #(
  parameter int DEPTH = 32,
  parameter int PEEK  = 4,
  localparam int AW    = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int POP_W = $clog2(PEEK + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 wr_en,
  input  logic [7:0]           wr_byte,
  input  logic [POP_W-1:0]     pop_n,
  output logic [PEEK-1:0][7:0] peek,
  output logic [CNT_W-1:0]     fill
);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_ptr, wr_ptr_d;
  logic [AW-1:0] rd_ptr, rd_ptr_d;
  logic [CNT_W-1:0] fill_d;
  logic          wr_go;

  assign wr_go = wr_en & ~flush;

  // Storage carries no reset; only pointers define validity.
  always_ff @(posedge clk) begin
    if (wr_go) begin
      mem[wr_ptr] <= wr_byte;
    end
  end

  // The next PEEK bytes from the head, oldest at index 0.
  for (genvar gi = 0; gi < PEEK; gi++) begin : g_peek
    assign peek[gi] = mem[rd_ptr + AW'(gi)];
  end

  always_comb begin
    wr_ptr_d = wr_ptr;
    rd_ptr_d = rd_ptr;
    fill_d   = fill;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      fill_d   = '0;
    end else begin
      if (wr_go) begin
        wr_ptr_d = wr_ptr + 1'b1;
      end
      rd_ptr_d = rd_ptr + AW'(pop_n);
      fill_d   = fill + CNT_W'(wr_go) - CNT_W'(pop_n);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      fill   <= '0;
    end else begin
      wr_ptr <= wr_ptr_d;
      rd_ptr <= rd_ptr_d;
      fill   <= fill_d;
    end
  end

  AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (fill < CNT_W'(DEPTH))); // R8
  AST_POP_WITHIN_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    CNT_W'(pop_n) <= fill); // R6

endmodule

// File: rtl/hrx_frame_track.sv
module hrx_frame_track
  import hrx_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int PEEK  = 4,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int POP_W = $clog2(PEEK + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             transparent,
  input  logic             rx_valid,
  input  logic             rx_eof,
  input  hrx_qual_t        qual_in,
  input  logic             host_rd,
  input  logic [CNT_W-1:0] fill,
  output logic             wr_en,
  output logic [POP_W-1:0] pop_n,
  output logic [CNT_W-1:0] avail,
  output logic             eom_pend,
  output hrx_qual_t        qual,
  output logic             ovf
);

  logic             eom_pend_d, ovf_d;
  logic [CNT_W-1:0] eom_len, eom_len_d;
  hrx_qual_t        qual_d;
  logic             byte_in, eof_framed, full, ovf_hit;

  assign full       = (fill == CNT_W'(DEPTH));
  assign byte_in    = rx_valid & ~flush;
  assign eof_framed = rx_eof & ~transparent;
  assign ovf_hit    = byte_in & ~ovf & (full | (eof_framed & eom_pend));
  assign wr_en      = byte_in & ~ovf & ~ovf_hit;
  assign avail      = eom_pend ? eom_len : fill;

  // A read stops at a pending frame boundary.
  always_comb begin
    pop_n = '0;
    if (host_rd && !flush) begin
      if (avail >= CNT_W'(PEEK)) begin
        pop_n = POP_W'(PEEK);
      end else begin
        pop_n = POP_W'(avail);
      end
    end
  end

  always_comb begin
    eom_pend_d = eom_pend;
    eom_len_d  = eom_len;
    qual_d     = qual;
    ovf_d      = ovf;
    if (flush) begin
      eom_pend_d = 1'b0;
      eom_len_d  = '0;
      qual_d     = '0;
      ovf_d      = 1'b0;
    end else begin
      ovf_d = ovf | ovf_hit;
      if (eom_pend) begin
        eom_len_d = eom_len - CNT_W'(pop_n);
        if (eom_len_d == '0) begin
          eom_pend_d = 1'b0;
        end
      end
      if (wr_en && eof_framed) begin
        eom_pend_d = 1'b1;
        eom_len_d  = fill - CNT_W'(pop_n) + 1'b1;
        qual_d     = qual_in;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eom_pend <= 1'b0;
      eom_len  <= '0;
      qual     <= '0;
      ovf      <= 1'b0;
    end else begin
      eom_pend <= eom_pend_d;
      eom_len  <= eom_len_d;
      qual     <= qual_d;
      ovf      <= ovf_d;
    end
  end

  AST_EOM_INSIDE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    eom_pend |-> (eom_len <= fill && eom_len != '0)); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !flush) |=> ovf); // R8
  AST_TRANSPARENT_NO_EOM: assert property (@(posedge clk) disable iff (!rst_n)
    (transparent && !eom_pend) |=> !eom_pend); // R11

endmodule

// File: rtl/hrx_word_pack.sv
module hrx_word_pack #(
  parameter int PEEK = 4,
  localparam int POP_W = $clog2(PEEK + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 host_rd,
  input  logic [POP_W-1:0]     pop_n,
  input  logic [PEEK-1:0][7:0] peek,
  output logic [8*PEEK-1:0]    rd_data
);

  logic [8*PEEK-1:0] rd_data_d;

  // Byte i of the word is valid only if i < pop_n; the rest read as zero.
  always_comb begin
    rd_data_d = rd_data;
    if (host_rd) begin
      for (int i = 0; i < PEEK; i++) begin
        rd_data_d[8*i +: 8] = (POP_W'(i) < pop_n) ? peek[i] : 8'h00;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else begin
      rd_data <= rd_data_d;
    end
  end

endmodule

// File: rtl/hdlc_rx_fifo_ctrl.sv
module hdlc_rx_fifo_ctrl
  import hrx_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        transparent_mode,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  input  logic        rx_eof,
  input  logic        rx_crc_ok,
  input  logic        rx_aligned,
  input  logic        rx_abort,
  input  logic        rx_reset_cmd,
  input  logic        host_rd,
  output logic [31:0] host_rdata,
  output logic [31:0] status_word,
  output logic        rpr_irq
);

  localparam int PEEK  = HOST_BYTES;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int POP_W = $clog2(PEEK + 1);

  logic                 wr_en;
  logic [POP_W-1:0]     pop_n;
  logic [PEEK-1:0][7:0] peek;
  logic [CNT_W-1:0]     fill;
  logic [CNT_W-1:0]     avail;
  logic                 eom_pend;
  logic                 ovf;
  hrx_qual_t            qual, qual_in;
  logic [CNT_FLD_W-1:0] cnt_code;

  assign qual_in = '{abort: rx_abort, aligned: rx_aligned, crc_ok: rx_crc_ok};

  hrx_byte_store #(.DEPTH(DEPTH), .PEEK(PEEK)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (rx_reset_cmd),
    .wr_en   (wr_en),
    .wr_byte (rx_byte),
    .pop_n   (pop_n),
    .peek    (peek),
    .fill    (fill)
  );

  hrx_frame_track #(.DEPTH(DEPTH), .PEEK(PEEK)) u_track (
    .clk         (clk),
    .rst_n       (rst_n),
    .flush       (rx_reset_cmd),
    .transparent (transparent_mode),
    .rx_valid    (rx_valid),
    .rx_eof      (rx_eof),
    .qual_in     (qual_in),
    .host_rd     (host_rd),
    .fill        (fill),
    .wr_en       (wr_en),
    .pop_n       (pop_n),
    .avail       (avail),
    .eom_pend    (eom_pend),
    .qual        (qual),
    .ovf         (ovf)
  );

  hrx_word_pack #(.PEEK(PEEK)) u_pack (
    .clk     (clk),
    .rst_n   (rst_n),
    .host_rd (host_rd),
    .pop_n   (pop_n),
    .peek    (peek),
    .rd_data (host_rdata)
  );

  // A full buffer reports its count as zero.
  assign cnt_code = (avail == CNT_W'(DEPTH)) ? '0 : CNT_FLD_W'(avail);
  assign rpr_irq  = ovf | eom_pend | (fill == CNT_W'(DEPTH));

  always_comb begin
    status_word                      = '0;
    status_word[ST_EOM]              = eom_pend;
    status_word[ST_QUAL +: 3]        = eom_pend ? qual : 3'b000;
    status_word[ST_OVF]              = ovf;
    status_word[ST_READY]            = rpr_irq;
    status_word[ST_CNT +: CNT_FLD_W] = cnt_code;
  end

  AST_RESET_CMD_FLUSHES: assert property (@(posedge clk) disable iff (!rst_n)
    rx_reset_cmd |=> (fill == '0 && !status_word[ST_OVF] && !rpr_irq)); // R10
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && fill == '0) |=> (host_rdata == '0 && fill == '0)); // R7

endmodule

// File: tb/hdlc_rx_fifo_ctrl_tb_top.sv
module hdlc_rx_fifo_ctrl_tb_top;

  logic        clk;
  logic        rst_n;
  logic        transparent_mode;
  logic        rx_valid;
  logic [7:0]  rx_byte;
  logic        rx_eof, rx_crc_ok, rx_aligned, rx_abort;
  logic        rx_reset_cmd;
  logic        host_rd;
  logic [31:0] host_rdata;
  logic [31:0] status_word;
  logic        rpr_irq;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  hdlc_rx_fifo_ctrl dut_i (
    .clk              (clk),
    .rst_n            (rst_n),
    .transparent_mode (transparent_mode),
    .rx_valid         (rx_valid),
    .rx_byte          (rx_byte),
    .rx_eof           (rx_eof),
    .rx_crc_ok        (rx_crc_ok),
    .rx_aligned       (rx_aligned),
    .rx_abort         (rx_abort),
    .rx_reset_cmd     (rx_reset_cmd),
    .host_rd          (host_rd),
    .host_rdata       (host_rdata),
    .status_word      (status_word),
    .rpr_irq          (rpr_irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Tasks start and end on a falling edge.
  task automatic push(input logic [7:0] b, input logic eof, input logic crc,
                      input logic aln, input logic abt);
    rx_valid = 1'b1; rx_byte = b; rx_eof = eof;
    rx_crc_ok = crc; rx_aligned = aln; rx_abort = abt;
    @(negedge clk);
    rx_valid = 1'b0; rx_eof = 1'b0; rx_crc_ok = 1'b0; rx_aligned = 1'b0; rx_abort = 1'b0;
  endtask

  task automatic read_word(output logic [31:0] w);
    host_rd = 1'b1;
    @(negedge clk);
    host_rd = 1'b0;
    w = host_rdata;
  endtask

  task automatic rx_reset(input logic with_byte);
    rx_reset_cmd = 1'b1;
    rx_valid = with_byte; rx_byte = 8'hEE;
    @(negedge clk);
    rx_reset_cmd = 1'b0; rx_valid = 1'b0;
  endtask

  task automatic t_reset_state();
    check("R1 status", status_word, 32'h0);
    check("R1 rdata", host_rdata, 32'h0);
    check("R1 irq", {31'b0, rpr_irq}, 32'h0);
  endtask

  task automatic t_transparent();
    logic [31:0] w;
    transparent_mode = 1'b1;
    for (int i = 1; i <= 5; i++) push(8'(i), (i == 5), 1'b1, 1'b1, 1'b0);
    check("R11 eof ignored", status_word, 32'h0000_0500);
    read_word(w);
    check("R2 word order", w, 32'h0403_0201);
    check("R2 count after read", status_word, 32'h0000_0100);
    read_word(w);
    check("R6 partial word zero-fill", w, 32'h0000_0005);
    read_word(w);
    check("R7 empty read data", w, 32'h0);
    check("R7 empty read count", status_word, 32'h0);
    for (int i = 1; i <= 31; i++) push(8'(i), 1'b0, 1'b0, 1'b0, 1'b0);
    check("R11 no irq below full", {31'b0, rpr_irq}, 32'h0);
    push(8'd32, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R3 full count zero, ready", status_word, 32'h0000_0020);
    check("R3 irq at full", {31'b0, rpr_irq}, 32'h1);
    read_word(w);
    check("R2 first word of 32", w, 32'h0403_0201);
    for (int i = 0; i < 6; i++) read_word(w);
    read_word(w);
    check("R2 last word of 32", w, 32'h201F_1E1D);
    check("R2 drained", status_word, 32'h0);
    transparent_mode = 1'b0;
  endtask

  task automatic t_good_frame();
    logic [31:0] w;
    for (int i = 0; i < 6; i++) push(8'h10 + 8'(i), (i == 5), 1'b1, 1'b1, 1'b0);
    check("R4 R5 frame end status", status_word, 32'h0000_0627);
    for (int i = 0; i < 3; i++) push(8'h20 + 8'(i), 1'b0, 1'b0, 1'b0, 1'b0);
    check("R4 count limited to frame", status_word, 32'h0000_0627);
    read_word(w);
    check("R2 frame word 1", w, 32'h1312_1110);
    check("R4 remaining tail", status_word, 32'h0000_0227);
    read_word(w);
    check("R6 stop at frame end", w, 32'h0000_1514);
    check("R6 eom cleared, next bytes", status_word, 32'h0000_0300);
    read_word(w);
    check("R6 next frame bytes", w, 32'h0022_2120);
    check("R6 empty after", status_word, 32'h0);
  endtask

  task automatic t_bad_frame();
    logic [31:0] w;
    push(8'h30, 1'b0, 1'b0, 1'b0, 1'b0);
    push(8'h31, 1'b1, 1'b0, 1'b1, 1'b1);
    check("R5 aborted quality", status_word, 32'h0000_022D);
    read_word(w);
    check("R5 bad frame data", w, 32'h0000_3130);
    check("R5 quality cleared", status_word, 32'h0);
  endtask

  task automatic t_overflow();
    logic [31:0] w;
    for (int i = 0; i < 32; i++) push(8'h40 + 8'(i), 1'b0, 1'b0, 1'b0, 1'b0);
    push(8'hAA, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R8 overflow flagged", status_word, 32'h0000_0030);
    read_word(w);
    check("R8 stored data intact", w, 32'h4342_4140);
    push(8'hBB, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R8 bytes dropped after overflow", status_word, 32'h0000_1C30);
    rx_reset(1'b1);
    check("R10 flushed and cleared", status_word, 32'h0);
    check("R10 irq low", {31'b0, rpr_irq}, 32'h0);
    push(8'h77, 1'b0, 1'b0, 1'b0, 1'b0);
    check("R10 works after release", status_word, 32'h0000_0100);
    read_word(w);
    check("R10 byte after release", w, 32'h0000_0077);
  endtask

  task automatic t_double_eof();
    push(8'h55, 1'b1, 1'b1, 1'b1, 1'b0);
    push(8'h66, 1'b1, 1'b1, 1'b1, 1'b0);
    check("R9 second frame end overflows", status_word, 32'h0000_0137);
    rx_reset(1'b0);
    check("R10 cleared after double eof", status_word, 32'h0);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    transparent_mode = 1'b0;
    rx_valid = 1'b0; rx_byte = 8'h00; rx_eof = 1'b0;
    rx_crc_ok = 1'b0; rx_aligned = 1'b0; rx_abort = 1'b0;
    rx_reset_cmd = 1'b0; host_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_transparent();
    t_good_frame();
    t_bad_frame();
    t_overflow();
    t_double_eof();
    done = 1;
    finish_run();
  end

endmodule